// File: doc/BRIEF.md
# Mini UART Register Front End

This block is the register-side half of a small serial port. A host reaches it over a plain 32-bit register bus: one address, a read strobe, a write strobe, and write and read data. It works in a 256-byte window. A byte-wide receive stream with valid/ready handshaking fills a circular receive queue. The host drains that queue by reading the data register. A write to the same register sends its low byte out on a transmit byte stream as a single-cycle pulse. Bit timing, the baud divider, and the line and modem control functions live elsewhere. Their registers are present in the map but read as zero.

The block keeps a two-bit interrupt enable. From it, and from the queue fill level, it derives a level-sensitive interrupt line. Several status words combine fixed constants with the fill state. A command through the interrupt-identify register discards everything held in the receive queue.

Read data is combinational: it is valid in the same cycle as the read strobe. Side effects of an access, such as popping the queue, storing the enable, flushing, or launching a transmit byte, take place at the clock edge that ends the access.

Top module: `mini_uart_regs`

## Requirements
- R1: Only the byte offsets 0x00, 0x04, 0x40, 0x44, 0x48, 0x54, 0x60 and 0x64 (taken from address bits [7:0]) return nonzero data. The line-control (0x4C), modem-control (0x50), modem-status (0x58), scratch (0x5C) and baud (0x68) offsets, any other or unaligned offset, all read 0. A write to any of those offsets changes no state.
- R2: Offset 0x04 always reads 0x1, and offset 0x60 always reads 0x3.
- R3: The receive count never exceeds DEPTH. `rx_ready` is high exactly when the count is below DEPTH and the current access is not a flush command. A byte offered while `rx_ready` is low is dropped.
- R4: Each accepted byte is stored at slot (read pointer + count) mod DEPTH. A data read (0x40) of a non-empty queue returns the byte at the read pointer, advances the pointer with wrap-around, and decrements the count. A push and a pop in the same cycle leave the count unchanged.
- R5: A data read of an empty queue returns the byte still held in the slot at the read pointer and changes neither the pointer nor the count.
- R6: A write to offset 0x44 stores only bits [1:0] (bit 0 enables receive, bit 1 enables transmit). A read of 0x44 returns 0xC0 OR those two bits.
- R7: The receive source is pending when bit 0 is enabled and the count is nonzero. The transmit source is pending whenever bit 1 is enabled. `irq` is high when either source is pending, and offset 0x00 then reads 1; otherwise it reads 0.
- R8: A read of offset 0x48 returns 0xC0 OR 0x4 if the queue is non-empty, or 0xC0 OR 0x2 if it is empty, with bit 0 additionally set when no source is pending.
- R9: A write to 0x48 with bit 1 set clears the count to zero and keeps the read pointer. A write to 0x48 with bit 1 clear has no effect.
- R10: Offset 0x54 reads 0x60, with bit 0 set when the queue holds at least one byte.
- R11: Offset 0x64 reads 0x30E, with bit 0 set when the queue is non-empty and the count placed from bit 16 upward (bits [19:16] for DEPTH 8).
- R12: A write to offset 0x40 raises `tx_valid` for exactly the following cycle, with `tx_data` equal to write-data bits [7:0]. No other access raises `tx_valid`.
- R13: A synchronous reset empties the queue, zeroes the read pointer and the enables, and drives `irq` and `tx_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address; bits [7:0] are decoded |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can take a byte this cycle |
| tx_valid | output | 1 | One-cycle pulse carrying an outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bound checker watches the following on every cycle: the fill count never passes the depth; `rx_ready` stays low at full; the count grows by one on an unopposed push; a flush command leaves the count at zero; an empty data read freezes the pointer and count; the transmit pulse follows a data write by one cycle with the written byte and appears at no other time; an enabled transmit source holds `irq` high. The following can only be shown by the bench's directed scenarios: the fixed composite read values, the first-in-first-out order across pointer wrap, the stale byte returned from an empty or flushed queue, and the receive-driven interrupt rising and falling with the fill level.

// File: rtl/mu_pkg.sv
package mu_pkg;

   localparam int unsigned MU_DW   = 32;
   localparam int unsigned MU_BW   = 8;
   localparam int unsigned MU_OFFW = 8;

   // Register window layout (byte offsets inside the 256-byte window)
   typedef enum logic [MU_OFFW-1:0] {
      MU_OFF_IRQSUM = 8'h00,
      MU_OFF_ENA    = 8'h04,
      MU_OFF_DATA   = 8'h40,
      MU_OFF_IEN    = 8'h44,
      MU_OFF_IID    = 8'h48,
      MU_OFF_LCTL   = 8'h4C,
      MU_OFF_MCTL   = 8'h50,
      MU_OFF_LSTAT  = 8'h54,
      MU_OFF_MSTAT  = 8'h58,
      MU_OFF_SCR    = 8'h5C,
      MU_OFF_XCTL   = 8'h60,
      MU_OFF_XSTAT  = 8'h64,
      MU_OFF_BAUD   = 8'h68
   } mu_off_e;

   // Fixed read constants
   localparam logic [MU_BW-1:0]  MU_IEN_FIX   = 8'hC0;
   localparam logic [MU_BW-1:0]  MU_IID_FIX   = 8'hC0;
   localparam logic [MU_BW-1:0]  MU_LSTAT_FIX = 8'h60;
   localparam logic [15:0]       MU_XSTAT_FIX = 16'h030E;
   localparam logic [MU_DW-1:0]  MU_XCTL_VAL  = 32'h3;
   localparam logic [MU_DW-1:0]  MU_ENA_VAL   = 32'h1;

   // Interrupt enable / pending bit positions
   localparam int unsigned MU_SRC_RX = 0;
   localparam int unsigned MU_SRC_TX = 1;

   typedef struct packed {
      logic irqsum;
      logic ena;
      logic data;
      logic ien;
      logic iid;
      logic lstat;
      logic xctl;
      logic xstat;
   } mu_sel_t;

   function automatic mu_sel_t mu_decode(input logic [MU_OFFW-1:0] off);
      mu_sel_t s;
      s        = '0;
      s.irqsum = (off == MU_OFF_IRQSUM);
      s.ena    = (off == MU_OFF_ENA);
      s.data   = (off == MU_OFF_DATA);
      s.ien    = (off == MU_OFF_IEN);
      s.iid    = (off == MU_OFF_IID);
      s.lstat  = (off == MU_OFF_LSTAT);
      s.xctl   = (off == MU_OFF_XCTL);
      s.xstat  = (off == MU_OFF_XSTAT);
      return s;
   endfunction

endpackage

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo
   import mu_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [MU_BW-1:0]  in_byte,
   output logic              in_ready,
   input  logic              flush,
   input  logic              pop_req,
   output logic [MU_BW-1:0]  head_byte,
   output logic [CNT_W-1:0]  fill,
   output logic [PTR_W-1:0]  head_ptr
);

   localparam int unsigned SUM_W = CNT_W + 1;
   localparam bit          POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [MU_BW-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] wr_idx;
   logic [PTR_W-1:0] rd_inc;
   logic [SUM_W-1:0] wr_sum;
   logic [SUM_W-1:0] rd_sum;
   logic             push_go;
   logic             pop_go;

   assign wr_sum = SUM_W'(rd_q) + SUM_W'(cnt_q);
   assign rd_sum = SUM_W'(rd_q) + SUM_W'(1);

   // Index wrap: free for power-of-two depths, compare-and-subtract otherwise
   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_idx = wr_sum[PTR_W-1:0];
         assign rd_inc = rd_sum[PTR_W-1:0];
      end else begin : g_wrap_mod
         assign wr_idx = (wr_sum >= SUM_W'(DEPTH)) ? PTR_W'(wr_sum - SUM_W'(DEPTH))
                                                   : PTR_W'(wr_sum);
         assign rd_inc = (rd_sum >= SUM_W'(DEPTH)) ? '0 : PTR_W'(rd_sum);
      end
   endgenerate

   assign in_ready = (cnt_q < CNT_W'(DEPTH)) && !flush;
   assign push_go  = in_valid && in_ready;
   assign pop_go   = pop_req && (cnt_q != '0) && !flush;

   always_ff @(posedge clk) begin
      if (push_go) begin
         slot_q[wr_idx] <= in_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (pop_go) begin
            rd_q <= rd_inc;
         end
         if (flush) begin
            cnt_q <= '0;
         end else if (push_go && !pop_go) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end else if (pop_go && !push_go) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign head_byte = slot_q[rd_q];
   assign fill      = cnt_q;
   assign head_ptr  = rd_q;

endmodule

// File: rtl/mu_irq_ctrl.sv
module mu_irq_ctrl
   import mu_pkg::*;
#(
   parameter int unsigned NSRC = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en_we,
   input  logic [NSRC-1:0] en_wdata,
   input  logic            rx_avail,
   output logic [NSRC-1:0] en,
   output logic [NSRC-1:0] pend,
   output logic            irq_o
);

   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] cond;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q <= '0;
      end else if (en_we) begin
         en_q <= en_wdata;
      end
   end

   // Per-source raw conditions; the transmit side is always ready
   always_comb begin
      cond            = '0;
      cond[MU_SRC_RX] = rx_avail;
      cond[MU_SRC_TX] = 1'b1;
   end

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         assign pend[g] = en_q[g] & cond[g];
      end
   endgenerate

   assign en    = en_q;
   assign irq_o = |pend;

endmodule

// File: rtl/mu_rd_mux.sv
module mu_rd_mux
   import mu_pkg::*;
#(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned NSRC  = 2
) (
   input  mu_sel_t           sel,
   input  logic              rd,
   input  logic [CNT_W-1:0]  fill,
   input  logic [MU_BW-1:0]  head_byte,
   input  logic [NSRC-1:0]   en,
   input  logic [NSRC-1:0]   pend,
   output logic [MU_DW-1:0]  rdata
);

   logic             nonempty;
   logic [MU_BW-1:0] iid_w;
   logic [15:0]      cnt_field;

   assign nonempty  = (fill != '0);
   assign cnt_field = 16'(fill);

   always_comb begin
      iid_w    = MU_IID_FIX | (nonempty ? 8'h04 : 8'h02);
      iid_w[0] = (pend == '0);
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (1'b1)
            sel.irqsum: rdata = {31'b0, (pend != '0)};
            sel.ena:    rdata = MU_ENA_VAL;
            sel.data:   rdata = {24'b0, head_byte};
            sel.ien:    rdata = {24'b0, MU_IEN_FIX | MU_BW'(en)};
            sel.iid:    rdata = {24'b0, iid_w};
            sel.lstat:  rdata = {24'b0, MU_LSTAT_FIX | {7'b0, nonempty}};
            sel.xctl:   rdata = MU_XCTL_VAL;
            sel.xstat:  rdata = {cnt_field, MU_XSTAT_FIX | {15'b0, nonempty}};
            default:    rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/mini_uart_regs.sv
module mini_uart_regs
   import mu_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned NSRC  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [MU_DW-1:0]  bus_wdata,
   output logic [MU_DW-1:0]  bus_rdata,
   input  logic              rx_valid,
   input  logic [MU_BW-1:0]  rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [MU_BW-1:0]  tx_data,
   output logic              irq
);

   generate
      if (DEPTH < 2 || DEPTH > 255) begin : g_bad_depth
         $error("mini_uart_regs: DEPTH must lie in 2..255");
      end
      if (ADDR_W < MU_OFFW) begin : g_bad_addr
         $error("mini_uart_regs: ADDR_W must cover the 256-byte window");
      end
      if (CNT_W > 16) begin : g_bad_cnt
         $error("mini_uart_regs: count does not fit the status field");
      end
   endgenerate

   mu_sel_t          sel;
   logic [CNT_W-1:0] fill_cnt;
   logic [PTR_W-1:0] rd_ptr;
   logic [MU_BW-1:0] head_byte;
   logic [NSRC-1:0]  ier;
   logic [NSRC-1:0]  pend;
   logic             flush_cmd;
   logic             pop_cmd;
   logic             ien_we;
   logic             tx_go;
   logic             tx_valid_q;
   logic [MU_BW-1:0] tx_data_q;

   assign sel       = mu_decode(bus_addr[MU_OFFW-1:0]);
   assign flush_cmd = bus_wr && sel.iid && bus_wdata[1];
   assign pop_cmd   = bus_rd && sel.data;
   assign ien_we    = bus_wr && sel.ien;
   assign tx_go     = bus_wr && sel.data;

   mu_rx_fifo #(
      .DEPTH (DEPTH)
   ) i_fifo (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (rx_valid),
      .in_byte   (rx_data),
      .in_ready  (rx_ready),
      .flush     (flush_cmd),
      .pop_req   (pop_cmd),
      .head_byte (head_byte),
      .fill      (fill_cnt),
      .head_ptr  (rd_ptr)
   );

   mu_irq_ctrl #(
      .NSRC (NSRC)
   ) i_irq (
      .clk      (clk),
      .rst      (rst),
      .en_we    (ien_we),
      .en_wdata (bus_wdata[NSRC-1:0]),
      .rx_avail (fill_cnt != '0),
      .en       (ier),
      .pend     (pend),
      .irq_o    (irq)
   );

   mu_rd_mux #(
      .CNT_W (CNT_W),
      .NSRC  (NSRC)
   ) i_rmux (
      .sel       (sel),
      .rd        (bus_rd),
      .fill      (fill_cnt),
      .head_byte (head_byte),
      .en        (ier),
      .pend      (pend),
      .rdata     (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_valid_q <= 1'b0;
         tx_data_q  <= '0;
      end else begin
         tx_valid_q <= tx_go;
         if (tx_go) begin
            tx_data_q <= bus_wdata[MU_BW-1:0];
         end
      end
   end

   assign tx_valid = tx_valid_q;
   assign tx_data  = tx_data_q;

endmodule

// File: rtl/mini_uart_regs_chk.sv
module mini_uart_regs_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic             clk,
   input logic             rst,
   input logic [7:0]       bus_addr,
   input logic             bus_rd,
   input logic             bus_wr,
   input logic [31:0]      bus_wdata,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic             tx_valid,
   input logic [7:0]       tx_data,
   input logic             irq,
   input logic [CNT_W-1:0] cnt,
   input logic [PTR_W-1:0] rd_ptr,
   input logic [1:0]       ier
);

   logic hit_data;
   logic hit_iid;
   logic pop_now;

   assign hit_data = (bus_addr == 8'h40);
   assign hit_iid  = (bus_addr == 8'h48);
   assign pop_now  = bus_rd && hit_data && (cnt != '0);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(DEPTH));

   assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
      (cnt == CNT_W'(DEPTH)) |-> !rx_ready);

   assert_push_grows_R4: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && rx_ready && !pop_now) |=> (cnt == $past(cnt) + CNT_W'(1)));

   assert_empty_read_still_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && hit_data && cnt == '0 && !(rx_valid && rx_ready))
      |=> (cnt == '0 && rd_ptr == $past(rd_ptr)));

   assert_tx_src_pends_R7: assert property (@(posedge clk) disable iff (rst)
      ier[1] |-> irq);

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && hit_iid && bus_wdata[1]) |=> (cnt == '0));

   assert_tx_pulse_R12: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && hit_data) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

   assert_tx_quiet_R12: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && hit_data) |=> !tx_valid);

endmodule

bind mini_uart_regs mini_uart_regs_chk #(
   .DEPTH (DEPTH)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_addr  (bus_addr[7:0]),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .irq       (irq),
   .cnt       (fill_cnt),
   .rd_ptr    (rd_ptr),
   .ier       (ier)
);

// File: tb/test_mini_uart_regs.sv
module test_mini_uart_regs;

   localparam int CLK_P = 10;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        irq;

   int n_run  = 0;
   int n_fail = 0;
   logic [31:0] rv;

   always #(CLK_P/2) clk = ~clk;

   mini_uart_regs #(.DEPTH(DEPTH), .ADDR_W(8)) i_mini_uart_regs (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic t_reset;
      #1;
      check("R13 irq after reset", {31'b0, irq}, 32'h0);
      check("R13 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
      check("R3 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
      expect_rd("R13 enables cleared", 8'h44, 32'hC0);
      expect_rd("R13 xstat empty", 8'h64, 32'h30E);
      expect_rd("R8 iid idle", 8'h48, 32'hC3);
      expect_rd("R7 summary idle", 8'h00, 32'h0);
   endtask

   task automatic t_fixed;
      expect_rd("R2 enables reg", 8'h04, 32'h1);
      expect_rd("R2 xctl reg", 8'h60, 32'h3);
      wr(8'h4C, 32'hFFFF_FFFF);
      wr(8'h50, 32'hFFFF_FFFF);
      wr(8'h5C, 32'hFFFF_FFFF);
      wr(8'h68, 32'hFFFF_FFFF);
      wr(8'h45, 32'h3);
      wr(8'h49, 32'h2);
      expect_rd("R1 lctl zero", 8'h4C, 32'h0);
      expect_rd("R1 mctl zero", 8'h50, 32'h0);
      expect_rd("R1 mstat zero", 8'h58, 32'h0);
      expect_rd("R1 scratch zero", 8'h5C, 32'h0);
      expect_rd("R1 baud zero", 8'h68, 32'h0);
      expect_rd("R1 unmapped zero", 8'h80, 32'h0);
      expect_rd("R1 unaligned zero", 8'h41, 32'h0);
      expect_rd("R1 ien untouched", 8'h44, 32'hC0);
      check("R1 irq untouched", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_ier;
      wr(8'h44, 32'hFF);
      expect_rd("R6 ien masked", 8'h44, 32'hC3);
      check("R7 tx source irq", {31'b0, irq}, 32'h1);
      expect_rd("R7 summary set", 8'h00, 32'h1);
      expect_rd("R8 iid empty pending", 8'h48, 32'hC2);
      wr(8'h44, 32'h1);
      check("R7 rx enabled empty", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_fifo;
      push(8'h11); push(8'h22); push(8'h33);
      #1 check("R7 rx source irq", {31'b0, irq}, 32'h1);
      expect_rd("R10 lstat nonempty", 8'h54, 32'h61);
      expect_rd("R11 xstat three", 8'h64, 32'h0003_030F);
      expect_rd("R8 iid data", 8'h48, 32'hC4);
      expect_rd("R4 pop first", 8'h40, 32'h11);
      expect_rd("R4 pop second", 8'h40, 32'h22);
      expect_rd("R11 xstat one", 8'h64, 32'h0001_030F);
      expect_rd("R4 pop third", 8'h40, 32'h33);
      #1 check("R7 rx irq falls", {31'b0, irq}, 32'h0);
      expect_rd("R8 iid drained", 8'h48, 32'hC3);
      expect_rd("R10 lstat empty", 8'h54, 32'h60);
      wr(8'h44, 32'h0);
   endtask

   task automatic t_full_wrap;
      for (int i = 0; i < DEPTH; i++) push(8'hA0 + 8'(i));
      #1 check("R3 ready low at full", {31'b0, rx_ready}, 32'h0);
      expect_rd("R11 xstat full", 8'h64, 32'h0008_030F);
      push(8'hEE);
      expect_rd("R3 count held at full", 8'h64, 32'h0008_030F);
      for (int i = 0; i < DEPTH; i++)
         expect_rd("R4 wrap order", 8'h40, 32'(8'hA0 + 8'(i)));
      #1 check("R3 ready after drain", {31'b0, rx_ready}, 32'h1);
      expect_rd("R5 stale read", 8'h40, 32'hA0);
      expect_rd("R5 stale read again", 8'h40, 32'hA0);
      expect_rd("R5 count unchanged", 8'h64, 32'h30E);
   endtask

   task automatic t_flush;
      push(8'h51); push(8'h52); push(8'h53);
      wr(8'h48, 32'h1);
      expect_rd("R9 no flush bit1 clear", 8'h64, 32'h0003_030F);
      wr(8'h48, 32'h2);
      expect_rd("R9 flushed", 8'h64, 32'h30E);
      expect_rd("R9 pointer kept", 8'h40, 32'h51);
      push(8'h77);
      expect_rd("R4 push after flush", 8'h40, 32'h77);
   endtask

   task automatic t_simul;
      logic [31:0] d;
      push(8'h61);
      @(negedge clk);
      bus_addr = 8'h40; bus_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h62;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; rx_valid = 1'b0;
      check("R4 simul pop data", d, 32'h61);
      expect_rd("R4 simul count kept", 8'h64, 32'h0001_030F);
      expect_rd("R4 simul next", 8'h40, 32'h62);
   endtask

   task automatic t_tx;
      wr(8'h40, 32'h1234_56AB);
      #1;
      check("R12 tx pulse", {31'b0, tx_valid}, 32'h1);
      check("R12 tx byte", {24'b0, tx_data}, 32'hAB);
      @(negedge clk); #1;
      check("R12 tx one cycle", {31'b0, tx_valid}, 32'h0);
      wr(8'h44, 32'h0);
      #1 check("R12 no pulse other write", {31'b0, tx_valid}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_fixed();
      t_ier();
      t_fifo();
      t_full_wrap();
      t_flush();
      t_simul();
      t_tx();
      wr(8'h44, 32'h3);
      push(8'h01);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1 check("R13 irq cleared by reset", {31'b0, irq}, 32'h0);
      expect_rd("R13 fifo cleared by reset", 8'h64, 32'h30E);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule